// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This block performs the arithmetic of a 32-bit integer divide instruction whose dividend is 64 bits wide. The upper half of the dividend comes from an auxiliary Y register value and the lower half from the low 32 bits of the first operand. The dividend is divided by a 32-bit divisor, either as unsigned numbers or as two's-complement signed numbers. Division truncates toward zero and the remainder is discarded. A quotient that does not fit in 32 bits is clamped to the nearest representable limit instead of wrapping.

The surrounding pipeline pulses `start` with the operands, the mode bits and the Y value. It then waits for the single-cycle `done` pulse. The divider works on magnitudes with a restoring shift-and-subtract loop that produces one quotient bit per cycle. A final cycle applies the sign and the saturation. When the divisor is zero, the divider reports a fault and withholds the register write. When the flag-setting variant is selected, it also reports whether the result was clamped.

Top module: `sat_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) the dividend is the 64-bit value {`y_in`, `opa`}. The quotient is truncated and returned zero-extended on `result` when it fits in 32 bits, with `result_we`=1 in the `done` cycle.
- R2: In signed mode (`signed_mode`=1), {`y_in`, `opa`} and `divisor` are two's-complement numbers. The quotient is truncated toward zero and returned sign-extended to 64 bits when it lies within -2^31 to 2^31-1.
- R3: A zero divisor gives `div_zero`=1 and `result_we`=0 in the `done` cycle, and `result` keeps its previous value.
- R4: In signed mode, a positive quotient above 2^31-1 produces `result` = 0x000000007FFFFFFF.
- R5: In signed mode, a negative quotient below -2^31 produces `result` = 0xFFFFFFFF80000000. A quotient of exactly -2^31 is returned unclamped, with the same bit pattern.
- R6: In unsigned mode, a quotient with any of bits 63..32 set produces `result` = 0x00000000FFFFFFFF.
- R7: With `set_flags`=1, `ovf_flag` is 1 in the `done` cycle exactly when R4, R5 or R6 clamped the result. With `set_flags`=0, `ovf_flag` stays 0. `carry_flag` is always 0.
- R8: When `start` is sampled at clock edge E, `busy` is high from E up to edge E+65 and `done` is high for exactly one cycle after edge E+65. With a zero divisor, `done` is high for one cycle after edge E+1.
- R9: `start` is ignored while `busy` is high: the operation already running completes with its own operands.
- R10: While reset is asserted, `busy`, `done`, `result_we`, `div_zero`, `ovf_flag` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| signed_mode | input | 1 | 1 = signed, 0 = unsigned |
| set_flags | input | 1 | Flag-setting variant select |
| y_in | input | 32 | Upper half of the dividend |
| opa | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient, clamped and extended |
| result_we | output | 1 | Destination write enable, valid with done |
| div_zero | output | 1 | Divide-by-zero fault, valid with done |
| ovf_flag | output | 1 | Clamping flag, valid with done |
| carry_flag | output | 1 | Carry flag, always 0 |

## Verification
The hardest cases are at the clamping boundaries.

- **Negative limit.** A quotient of exactly -2^31 must pass through unchanged, while one just beyond it must clamp. This needs dividends built from a Y half of all ones or all zeros joined with operands near 0x80000000.
- **Most negative dividend.** The dividend -2^63 has a magnitude that fills all 64 bits. The stimulus reaches it with Y = 0x80000000, an operand of 0 and a divisor of -1.
- **Start while busy.** This case only appears if a second `start` arrives mid-run. The bench pulses a start with different operands partway through a division and checks that the first result and its latency are unchanged.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;
endpackage

// File: rtl/div_operand.sv
`timescale 1ns/1ps
// Forms the wide dividend and takes magnitudes of both operands.
module div_operand #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   hi_half,
  input  logic [XLEN-1:0]   lo_half,
  input  logic [XLEN-1:0]   dsr_raw,
  input  logic              sgn,
  output logic [2*XLEN-1:0] dvd_mag,
  output logic [XLEN-1:0]   dsr_mag,
  output logic              q_neg
);
  localparam int W2 = 2 * XLEN;

  logic [W2-1:0] dvd_raw;
  logic          dvd_neg;
  logic          dsr_neg;

  always_comb begin
    dvd_raw = {hi_half, lo_half};
    dvd_neg = sgn & dvd_raw[W2-1];
    dsr_neg = sgn & dsr_raw[XLEN-1];
    dvd_mag = dvd_neg ? (~dvd_raw + W2'(1)) : dvd_raw;
    dsr_mag = dsr_neg ? (~dsr_raw + XLEN'(1)) : dsr_raw;
    q_neg   = dvd_neg ^ dsr_neg;
  end
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
// One restoring iteration: shift in a dividend bit, trial subtract, emit a quotient bit.
module div_step #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   rem_in,
  input  logic [2*XLEN-1:0] dvd_in,
  input  logic [XLEN-1:0]   dsr,
  output logic [XLEN-1:0]   rem_out,
  output logic [2*XLEN-1:0] dvd_out
);
  localparam int W2 = 2 * XLEN;

  logic [XLEN:0] shifted;
  logic [XLEN:0] diff;
  logic          fits;

  always_comb begin
    shifted = {rem_in, dvd_in[W2-1]};
    diff    = shifted - {1'b0, dsr};
    fits    = ~diff[XLEN];
    rem_out = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    dvd_out = {dvd_in[W2-2:0], fits};
  end
endmodule

// File: rtl/div_resolve.sv
`timescale 1ns/1ps
// Applies the quotient sign and clamps to the XLEN-bit range of the selected mode.
module div_resolve #(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] qmag,
  input  logic              q_neg,
  input  logic              sgn,
  output logic [2*XLEN-1:0] res,
  output logic              sat
);
  localparam int W2 = 2 * XLEN;
  localparam logic [W2-1:0] U_MAX = {{XLEN{1'b0}}, {XLEN{1'b1}}};
  localparam logic [W2-1:0] S_MAX = {{(XLEN+1){1'b0}}, {(XLEN-1){1'b1}}};
  localparam logic [W2-1:0] S_MIN = {{(XLEN+1){1'b1}}, {(XLEN-1){1'b0}}};

  logic hi_any;
  logic top_bit;
  logic low_any;

  always_comb begin
    hi_any  = |qmag[W2-1:XLEN];
    top_bit = qmag[XLEN-1];
    low_any = |qmag[XLEN-2:0];
    if (!sgn) begin
      sat = hi_any;
      res = sat ? U_MAX : qmag;
    end else if (!q_neg) begin
      sat = hi_any | top_bit;
      res = sat ? S_MAX : qmag;
    end else begin
      sat = hi_any | (top_bit & low_any);
      res = sat ? S_MIN : (~qmag + W2'(1));
    end
  end
endmodule

// File: rtl/sat_divider.sv
`timescale 1ns/1ps
module sat_divider #(
  parameter int XLEN = 32,
  parameter int BPC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic              set_flags,
  input  logic [XLEN-1:0]   y_in,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   divisor,
  output logic              busy,
  output logic              done,
  output logic [2*XLEN-1:0] result,
  output logic              result_we,
  output logic              div_zero,
  output logic              ovf_flag,
  output logic              carry_flag
);
  import sdiv_pkg::*;

  localparam int W2    = 2 * XLEN;
  localparam int ITER  = W2 / BPC;
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  dstate_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [XLEN-1:0]  rem_q, rem_d;
  logic [W2-1:0]    dvd_q, dvd_d;
  logic [XLEN-1:0]  dsr_q, dsr_d;
  logic             neg_q, neg_d;
  logic             sgn_q, sgn_d;
  logic             setf_q, setf_d;
  logic             zero_q, zero_d;
  logic [W2-1:0]    res_q, res_d;
  logic             done_q, done_d;
  logic             we_q, we_d;
  logic             dz_q, dz_d;
  logic             ovf_q, ovf_d;
  logic             op_en;

  logic [W2-1:0]    op_dvd_mag;
  logic [XLEN-1:0]  op_dsr_mag;
  logic             op_neg;
  logic [W2-1:0]    fix_res;
  logic             fix_sat;

  logic [XLEN-1:0]  rem_c [BPC+1];
  logic [W2-1:0]    dvd_c [BPC+1];

  div_operand #(.XLEN(XLEN)) u_opnd (
    .hi_half (y_in),
    .lo_half (opa),
    .dsr_raw (divisor),
    .sgn     (signed_mode),
    .dvd_mag (op_dvd_mag),
    .dsr_mag (op_dsr_mag),
    .q_neg   (op_neg)
  );

  assign rem_c[0] = rem_q;
  assign dvd_c[0] = dvd_q;

  for (genvar g = 0; g < BPC; g++) begin : g_step
    div_step #(.XLEN(XLEN)) u_step (
      .rem_in  (rem_c[g]),
      .dvd_in  (dvd_c[g]),
      .dsr     (dsr_q),
      .rem_out (rem_c[g+1]),
      .dvd_out (dvd_c[g+1])
    );
  end

  div_resolve #(.XLEN(XLEN)) u_res (
    .qmag  (dvd_q),
    .q_neg (neg_q),
    .sgn   (sgn_q),
    .res   (fix_res),
    .sat   (fix_sat)
  );

  assign op_en = (st_q == ST_IDLE) && start;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dvd_d  = dvd_q;
    dsr_d  = dsr_q;
    neg_d  = neg_q;
    sgn_d  = sgn_q;
    setf_d = setf_q;
    zero_d = zero_q;
    res_d  = res_q;
    done_d = 1'b0;
    we_d   = 1'b0;
    dz_d   = 1'b0;
    ovf_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (op_en) begin
          dvd_d  = op_dvd_mag;
          dsr_d  = op_dsr_mag;
          neg_d  = op_neg;
          sgn_d  = signed_mode;
          setf_d = set_flags;
          rem_d  = '0;
          cnt_d  = '0;
          zero_d = (divisor == '0);
          st_d   = (divisor == '0) ? ST_FIX : ST_RUN;
        end
      end
      ST_RUN: begin
        rem_d = rem_c[BPC];
        dvd_d = dvd_c[BPC];
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == LAST) st_d = ST_FIX;
      end
      ST_FIX: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
        if (zero_q) begin
          dz_d = 1'b1;
        end else begin
          res_d = fix_res;
          we_d  = 1'b1;
          ovf_d = setf_q & fix_sat;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvd_q  <= '0;
      dsr_q  <= '0;
      neg_q  <= 1'b0;
      sgn_q  <= 1'b0;
      setf_q <= 1'b0;
      zero_q <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
      dz_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      dvd_q  <= dvd_d;
      dsr_q  <= dsr_d;
      neg_q  <= neg_d;
      sgn_q  <= sgn_d;
      setf_q <= setf_d;
      zero_q <= zero_d;
      res_q  <= res_d;
      done_q <= done_d;
      we_q   <= we_d;
      dz_q   <= dz_d;
      ovf_q  <= ovf_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign result     = res_q;
  assign result_we  = we_q;
  assign div_zero   = dz_q;
  assign ovf_flag   = ovf_q;
  assign carry_flag = 1'b0;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  hold_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dsr_q) && $stable(sgn_q)));

  // R3
  zero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (!result_we && !ovf_flag));

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> $stable(result));

  // R6
  unsigned_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_we && !sgn_q) |-> (result[W2-1:XLEN] == '0));

  // R2
  signed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_we && sgn_q) |->
      ((result[W2-1:XLEN-1] == '0) || (result[W2-1:XLEN-1] == '1)));

  // R7
  no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !setf_q) |-> !ovf_flag);
endmodule

// File: tb/sim_sat_divider.sv
`timescale 1ns/1ps
module sim_sat_divider;
  localparam int NV        = 14;
  localparam int LAT_FULL  = 66;
  localparam int LAT_ZERO  = 2;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        signed_mode;
  logic        set_flags;
  logic [31:0] y_in;
  logic [31:0] opa;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic [63:0] result;
  logic        result_we;
  logic        div_zero;
  logic        ovf_flag;
  logic        carry_flag;

  int checks;
  int fails;

  // {signed, set_flags, y, opa, divisor, expected result, expected ovf}
  localparam logic [162:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'h0000_0000, 32'd100,       32'd7,         64'h0000_0000_0000_000E, 1'b0},
    {1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'd2,         64'h0000_0000_8000_0000, 1'b0},
    {1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'd1,         64'h0000_0000_FFFF_FFFF, 1'b1},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7,         64'hFFFF_FFFF_FFFF_FFF2, 1'b0},
    {1'b1, 1'b1, 32'h0000_0000, 32'd100,       32'hFFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFF2, 1'b0},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 64'h0000_0000_0000_000E, 1'b0},
    {1'b1, 1'b1, 32'h0000_0000, 32'h8000_0000, 32'd1,         64'h0000_0000_7FFF_FFFF, 1'b1},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1,         64'hFFFF_FFFF_8000_0000, 1'b0},
    {1'b1, 1'b1, 32'h0000_0000, 32'h8000_0002, 32'hFFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 1'b1},
    {1'b1, 1'b1, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b1},
    {1'b1, 1'b1, 32'h0000_0000, 32'h7FFF_FFFF, 32'd1,         64'h0000_0000_7FFF_FFFF, 1'b0},
    {1'b0, 1'b0, 32'h0000_0005, 32'h0000_0000, 32'd1,         64'h0000_0000_FFFF_FFFF, 1'b0},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2,         64'hFFFF_FFFF_FFFF_FFFD, 1'b0},
    {1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0}
  };

  localparam string TAG [NV] = '{
    "R1", "R1", "R6", "R2", "R2", "R2", "R4",
    "R5", "R5", "R4", "R4", "R7", "R2", "R1"
  };

  sat_divider u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .set_flags   (set_flags),
    .y_in        (y_in),
    .opa         (opa),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .result_we   (result_we),
    .div_zero    (div_zero),
    .ovf_flag    (ovf_flag),
    .carry_flag  (carry_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Launch one division and wait for done; returns cycles from the start edge.
  task automatic run_div(input logic sg, input logic sf, input logic [31:0] y,
                         input logic [31:0] a, input logic [31:0] d,
                         output int lat);
    @(negedge clk);
    signed_mode = sg;
    set_flags   = sf;
    y_in        = y;
    opa         = a;
    divisor     = d;
    start       = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin
    automatic int lat = 0;
    automatic logic [63:0] prev;
    checks      = 0;
    fails       = 0;
    rst_n       = 1'b0;
    start       = 1'b0;
    signed_mode = 1'b0;
    set_flags   = 1'b0;
    y_in        = '0;
    opa         = '0;
    divisor     = '0;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "busy in reset", 64'(busy), 64'd0);
    check("R10", "done in reset", 64'(done), 64'd0);
    check("R10", "result in reset", result, 64'd0);
    check("R10", "flags in reset", 64'({result_we, div_zero, ovf_flag}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_div(VEC[i][162], VEC[i][161], VEC[i][160:129], VEC[i][128:97],
              VEC[i][96:65], lat);
      check(TAG[i], $sformatf("vec %0d result", i), result, VEC[i][64:1]);
      check("R7", $sformatf("vec %0d ovf_flag", i), 64'(ovf_flag), 64'(VEC[i][0]));
      check("R7", $sformatf("vec %0d carry_flag", i), 64'(carry_flag), 64'd0);
      check("R1", $sformatf("vec %0d result_we", i), 64'(result_we), 64'd1);
      check("R8", $sformatf("vec %0d latency", i), 64'(lat), 64'(LAT_FULL));
    end

    // R8: done lasts one cycle
    @(negedge clk);
    check("R8", "done single cycle", 64'(done), 64'd0);

    // R3: zero divisor, destination kept
    prev = result;
    run_div(1'b1, 1'b1, 32'h0000_0000, 32'd55, 32'd0, lat);
    check("R3", "div_zero", 64'(div_zero), 64'd1);
    check("R3", "result_we on zero", 64'(result_we), 64'd0);
    check("R3", "result held", result, prev);
    check("R3", "ovf on zero", 64'(ovf_flag), 64'd0);
    check("R8", "zero latency", 64'(lat), 64'(LAT_ZERO));

    // R9: start during busy is ignored
    @(negedge clk);
    signed_mode = 1'b0;
    set_flags   = 1'b1;
    y_in        = 32'h0;
    opa         = 32'd1000;
    divisor     = 32'd10;
    start       = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    repeat (10) begin
      @(negedge clk);
      lat++;
    end
    check("R8", "busy mid run", 64'(busy), 64'd1);
    signed_mode = 1'b1;
    y_in        = 32'hFFFF_FFFF;
    opa         = 32'hFFFF_FFF0;
    divisor     = 32'd0;
    start       = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    check("R9", "ignored start result", result, 64'd100);
    check("R9", "ignored start div_zero", 64'(div_zero), 64'd0);
    check("R9", "ignored start latency", 64'(lat), 64'(LAT_FULL));

    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule